// File: doc/BRIEF.md
# Multi-Shape Direct Digital Synthesis Generator

This block is the waveform core of a direct digital synthesis source. A 48-bit phase register gains a programmable tuning word on every clock and wraps around, so the tuning word sets the output frequency as a fraction of the clock. The uppermost phase bits are shaped into a 14-bit converter sample. The shape is chosen by a 3-bit select code: rising ramp, falling ramp, square, triangle, a user-loaded table, or a sine value produced by a separate quarter-wave block and fed in as an input.

The user table holds 1024 words of 14 bits. It is loaded through a simple write port, which accepts writes at any time, including during reset. It is indexed by the ten uppermost phase bits. The table read takes one cycle, so every other path is held back by one stage to match. The sample therefore always reflects the select code, phase and sine input of one common cycle. The sample leaves the block from a flip-flop.

Top module: `dds_wavegen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the phase register and `dac_sample` are cleared to 0. After release, the first phase value used is 0.
- R2: At each rising edge out of reset, the phase register becomes its previous value plus `tuning_word`, modulo 2^48.
- R3: Select code 0 gives a rising ramp: the sample equals phase bits [47:34].
- R4: Select code 1 gives a falling ramp: the sample equals the bitwise inverse of phase bits [47:34].
- R5: Select code 2 gives a square wave: the sample is 14'h3FFF when phase bit 47 is 1, and 14'h0000 otherwise.
- R6: Select code 3 gives a triangle. The 15-bit value v = phase[47:33] gives the sample v when v < 16384, and 32767 - v otherwise. This is a four-quadrant fold on phase bits [47:46].
- R7: Select code 4 gives the table word at address phase[47:38]. A write to the same address on the same edge as the read returns the old word.
- R8: Select code 5 passes `sine_sample` through to the output.
- R9: Select codes 6 and 7 behave like code 0.
- R10: The sample that appears after rising edge t+1 is computed from `shape_sel`, `sine_sample` and the phase value present at edge t. This holds even when `shape_sel` changes on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tuning_word | input | 48 | Phase increment added each cycle |
| shape_sel | input | 3 | Waveform select code |
| sine_sample | input | 14 | Sample from the external sine block |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_addr | input | 10 | Table write address |
| tbl_wr_data | input | 14 | Table write word |
| dac_sample | output | 14 | Registered output sample |

## Verification
The hardest case to reach from the ports is a table write that lands on the very word the phase is reading on the same edge. The stimulus reaches it by deriving the write address from the bench's own phase model, so each write targets the address currently being read. The other subtle case is alignment across a select change. The stimulus covers it by changing the select code and the sine input on every cycle, while a large tuning word moves the phase far between cycles. A misaligned stage then shows up as a wrong sample at once.

// File: rtl/dds_pkg.sv
// Package of shared types for the DDS generator.
// Assumes a 3-bit select code; unlisted codes fall back to the ramp.
package dds_pkg;
    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SHP_RAMP_UP  = 3'd0,
        SHP_RAMP_DN  = 3'd1,
        SHP_SQUARE   = 3'd2,
        SHP_TRIANGLE = 3'd3,
        SHP_TABLE    = 3'd4,
        SHP_SINE     = 3'd5,
        SHP_SPARE6   = 3'd6,
        SHP_SPARE7   = 3'd7
    } shape_e;
endpackage

// File: rtl/dds_phase_acc.sv
// Phase accumulator: adds the tuning word on every clock, wrapping at 2^PHASE_W.
// Assumes a synchronous active-low reset that clears the phase.
module dds_phase_acc #(
    parameter int PHASE_W = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] tuning,
    output logic [PHASE_W-1:0] phase
);
    // Advance the phase; the carry out of the top bit is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else begin
            phase <= phase + tuning;
        end
    end
endmodule

// File: rtl/dds_shape_table.sv
// User waveform table: one write port and one registered read port.
// Assumes the contents are not reset; a read and a write to the same
// address on one edge return the old word.
module dds_shape_table #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    // Read with one cycle of latency; the old word wins on a collision.
    always_ff @(posedge clk) begin
        rd_data <= store[rd_addr];
    end

    // Write whenever the strobe is high, independent of reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
    end
endmodule

// File: rtl/dds_shape_mux.sv
// Shape stage: aligns the phase, select and sine to the table latency,
// then forms the chosen shape into a registered output sample.
// Assumes table_data arrives one cycle after the phase that addressed it.
module dds_shape_mux
    import dds_pkg::*;
#(
    parameter int PHASE_W = 48,
    parameter int OUT_W   = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  shape_e             shape,
    input  logic [PHASE_W-1:0] phase,
    input  logic [OUT_W-1:0]   sine,
    input  logic [OUT_W-1:0]   table_data,
    output logic [OUT_W-1:0]   sample
);
    localparam int TOP_W = OUT_W + 1;
    localparam int MID_W = OUT_W - 1;

    shape_e           shape_q;
    logic [TOP_W-1:0] top_q;
    logic [OUT_W-1:0] sine_q;
    logic [OUT_W-1:0] ramp;
    logic [OUT_W-1:0] square;
    logic [OUT_W-1:0] tri_wave;
    logic [1:0]       quadrant;
    logic [MID_W-1:0] mid;
    logic [OUT_W-1:0] shaped;

    // Hold the inputs for one cycle to line them up with the table read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shape_q <= SHP_RAMP_UP;
            top_q   <= '0;
            sine_q  <= '0;
        end else begin
            shape_q <= shape;
            top_q   <= phase[PHASE_W-1 -: TOP_W];
            sine_q  <= sine;
        end
    end

    assign ramp     = top_q[TOP_W-1 -: OUT_W];
    assign square   = {OUT_W{top_q[TOP_W-1]}};
    assign quadrant = top_q[TOP_W-1 -: 2];
    assign mid      = top_q[MID_W-1:0];

    // Fold the triangle on the two top phase bits.
    always_comb begin
        unique case (quadrant)
            2'd0:    tri_wave = {1'b0, mid};
            2'd1:    tri_wave = {1'b1, mid};
            2'd2:    tri_wave = {1'b1, ~mid};
            default: tri_wave = {1'b0, ~mid};
        endcase
    end

    // Pick the shape; spare codes fall back to the rising ramp.
    always_comb begin
        unique case (shape_q)
            SHP_RAMP_DN:  shaped = ~ramp;
            SHP_SQUARE:   shaped = square;
            SHP_TRIANGLE: shaped = tri_wave;
            SHP_TABLE:    shaped = table_data;
            SHP_SINE:     shaped = sine_q;
            default:      shaped = ramp;
        endcase
    end

    // Register the output so the converter always sees a flip-flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample <= '0;
        end else begin
            sample <= shaped;
        end
    end
endmodule

// File: rtl/dds_wavegen.sv
// Top of the DDS generator: phase accumulator, user table and shape stage.
// Assumes the sine sample is supplied by an external quarter-wave block.
module dds_wavegen
    import dds_pkg::*;
#(
    parameter int PHASE_W = 48,
    parameter int OUT_W   = 14,
    parameter int TBL_AW  = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] tuning_word,
    input  logic [SEL_W-1:0]   shape_sel,
    input  logic [OUT_W-1:0]   sine_sample,
    input  logic               tbl_wr_en,
    input  logic [TBL_AW-1:0]  tbl_wr_addr,
    input  logic [OUT_W-1:0]   tbl_wr_data,
    output logic [OUT_W-1:0]   dac_sample
);
    logic [PHASE_W-1:0] phase_w;
    logic [OUT_W-1:0]   tbl_rd_data;
    shape_e             shape_w;

    assign shape_w = shape_e'(shape_sel);

    dds_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .tuning (tuning_word),
        .phase  (phase_w)
    );

    dds_shape_table #(.ADDR_W(TBL_AW), .DATA_W(OUT_W)) u_table (
        .clk     (clk),
        .rd_addr (phase_w[PHASE_W-1 -: TBL_AW]),
        .rd_data (tbl_rd_data),
        .wr_en   (tbl_wr_en),
        .wr_addr (tbl_wr_addr),
        .wr_data (tbl_wr_data)
    );

    dds_shape_mux #(.PHASE_W(PHASE_W), .OUT_W(OUT_W)) u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .shape      (shape_w),
        .phase      (phase_w),
        .sine       (sine_sample),
        .table_data (tbl_rd_data),
        .sample     (dac_sample)
    );
endmodule

// File: rtl/dds_wavegen_chk.sv
// Checker for dds_wavegen, bound to every instance of the top.
// Assumes outputs settle on the rising edge; a counter guards history use.
module dds_wavegen_chk #(
    parameter int PHASE_W = 48,
    parameter int OUT_W   = 14,
    parameter int SEL_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [PHASE_W-1:0] tuning,
    input logic [SEL_W-1:0]   sel,
    input logic [OUT_W-1:0]   sine,
    input logic [PHASE_W-1:0] phase,
    input logic [OUT_W-1:0]   sample
);
    logic [1:0] since_rst;

    // Count edges since reset release, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (sample == '0 && phase == '0));

    assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        since_rst >= 2'd1 |-> phase == $past(phase) + $past(tuning));

    assert_ramp_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && $past(sel, 2) == 3'd0)
        |-> sample == $past(phase[PHASE_W-1 -: OUT_W], 2));

    assert_ramp_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && $past(sel, 2) == 3'd1)
        |-> sample == ~$past(phase[PHASE_W-1 -: OUT_W], 2));

    assert_square_levels_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && $past(sel, 2) == 3'd2)
        |-> sample == {OUT_W{$past(phase[PHASE_W-1], 2)}});

    assert_sine_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && $past(sel, 2) == 3'd5)
        |-> sample == $past(sine, 2));

    assert_spare_codes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && $past(sel[2:1], 2) == 2'b11)
        |-> sample == $past(phase[PHASE_W-1 -: OUT_W], 2));
endmodule

bind dds_wavegen dds_wavegen_chk #(
    .PHASE_W (PHASE_W),
    .OUT_W   (OUT_W),
    .SEL_W   (dds_pkg::SEL_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tuning (tuning_word),
    .sel    (shape_sel),
    .sine   (sine_sample),
    .phase  (phase_w),
    .sample (dac_sample)
);

// File: tb/test_dds_wavegen.sv
// Bench for dds_wavegen: a behavioural model updated at each rising edge,
// compared with the output at every falling edge.
module test_dds_wavegen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] tuning_word = '0;
    logic [2:0]  shape_sel = '0;
    logic [13:0] sine_sample = '0;
    logic        tbl_wr_en = 1'b0;
    logic [9:0]  tbl_wr_addr = '0;
    logic [13:0] tbl_wr_data = '0;
    logic [13:0] dac_sample;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    logic [47:0] m_phase = '0;
    int          m_stage = 0;
    int          m_out = 0;
    int          m_tbl [1024];

    always #2.5 clk = ~clk;

    dds_wavegen i_dds_wavegen (
        .clk         (clk),
        .rst_n       (rst_n),
        .tuning_word (tuning_word),
        .shape_sel   (shape_sel),
        .sine_sample (sine_sample),
        .tbl_wr_en   (tbl_wr_en),
        .tbl_wr_addr (tbl_wr_addr),
        .tbl_wr_data (tbl_wr_data),
        .dac_sample  (dac_sample)
    );

    // Expected shape value from the requirement formulas.
    function automatic int expect_shape(input logic [2:0] s, input logic [47:0] p,
                                        input int sn, input int tv);
        int ramp;
        int v;
        ramp = int'(p >> 34);
        v    = int'(p >> 33);
        case (s)
            3'd1:    return 16383 - ramp;                          // R4
            3'd2:    return p[47] ? 16383 : 0;                     // R5
            3'd3:    return (v < 16384) ? v : 32767 - v;           // R6
            3'd4:    return tv;                                    // R7
            3'd5:    return sn;                                    // R8
            default: return ramp;                                  // R3, R9
        endcase
    endfunction

    // Reference model: two-step latency (R10), wrap (R2), reset (R1).
    always @(posedge clk) begin
        if (!rst_n) begin
            m_out   = 0;
            m_stage = 0;
            m_phase = '0;
        end else begin
            m_out   = m_stage;
            m_stage = expect_shape(shape_sel, m_phase, int'(sine_sample),
                                   m_tbl[int'(m_phase >> 38)]);
            m_phase = m_phase + tuning_word;
        end
        if (tbl_wr_en) m_tbl[int'(tbl_wr_addr)] = int'(tbl_wr_data);
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            n_cmp++;
            if (int'(dac_sample) != m_out) begin
                n_bad++;
                $display("FAIL %s: sample %0d expected %0d at %0t",
                         cur_req, dac_sample, m_out, $time);
            end
        end
    endtask

    initial begin
        @(negedge clk);
        // R1: reset holds the output at zero while the table is loaded.
        cur_req = "R1";
        for (int a = 0; a < 1024; a++) begin
            tbl_wr_en   = 1'b1;
            tbl_wr_addr = 10'(a);
            tbl_wr_data = 14'((a * 37 + 5) & 16'h3FFF);
            cyc(1);
        end
        tbl_wr_en = 1'b0;
        cyc(3);
        // R3 and R2: rising ramp with a large step.
        cur_req = "R3"; tuning_word = 48'h0001_2345_6789; shape_sel = 3'd0;
        rst_n = 1'b1; cyc(150);
        cur_req = "R2"; tuning_word = 48'h0123_4567_89AB; cyc(100);
        // R4: falling ramp.
        cur_req = "R4"; shape_sel = 3'd1; cyc(150);
        // R5: square with a short period.
        cur_req = "R5"; shape_sel = 3'd2; tuning_word = 48'h0400_0000_1235; cyc(200);
        // R6: triangle across all quadrants.
        cur_req = "R6"; shape_sel = 3'd3; tuning_word = 48'h0100_0000_0777; cyc(600);
        // R7: table read, with writes to the address being read.
        cur_req = "R7"; shape_sel = 3'd4; tuning_word = 48'h0040_1000_0003; cyc(300);
        for (int k = 0; k < 200; k++) begin
            tbl_wr_en   = 1'b1;
            tbl_wr_addr = m_phase[47:38];
            tbl_wr_data = 14'((k * 911 + 77) & 16'h3FFF);
            cyc(1);
        end
        tbl_wr_en = 1'b0; cyc(300);
        // R8: sine input passed through while it changes every cycle.
        cur_req = "R8"; shape_sel = 3'd5;
        for (int k = 0; k < 100; k++) begin
            sine_sample = 14'((k * 163 + 9) & 16'h3FFF);
            cyc(1);
        end
        // R9: spare codes.
        cur_req = "R9"; shape_sel = 3'd6; cyc(100);
        shape_sel = 3'd7; cyc(100);
        // R10: select and sine change every cycle.
        cur_req = "R10"; tuning_word = 48'h3456_789A_BCDF;
        for (int k = 0; k < 400; k++) begin
            shape_sel   = 3'((k * 5 + k / 8) % 8);
            sine_sample = 14'((k * 4099) & 16'h3FFF);
            cyc(1);
        end
        // R2: negative step forces wrap below zero.
        cur_req = "R2"; shape_sel = 3'd0; tuning_word = 48'hFFFF_FFFF_FFFF; cyc(50);
        tuning_word = 48'hF800_0000_0001; cyc(100);
        // R1: reset in mid-run, then the ramp restarts from phase 0.
        cur_req = "R1"; rst_n = 1'b0; cyc(4);
        rst_n = 1'b1; tuning_word = 48'h0000_4000_0000; cyc(50);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not end, actual running expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule